// File: doc/BRIEF.md
# Cached Page-Number Translator

This block turns a virtual page number into a physical frame number for a single requester. Each request is first compared against every slot of a small, fully associative translation cache at once. On a hit, the cached frame comes back after one lookup cycle and no memory traffic is generated.

On a miss, the block reads one page-table entry from main memory at the table base plus the page number. It checks the entry's valid and permission bits and responds. Any valid entry is then written into the cache. A length register bounds the table, and a page number outside it faults before any memory read is made. Switching to another table takes one write to the base register, and that write also empties the cache.

Only one translation is in flight at a time. The requester waits while `busy_o` is high and collects the result from a one-cycle response pulse.

Top module: `xlat_unit`

## Requirements
- R1: Every slot is compared with the page number in parallel. On a hit, the response follows the first clock edge after the accepting edge, and no memory read is issued.
- R2: On a miss within range, exactly one read is issued, with `mem_addr_o` equal to base plus page number (one table entry per address). The entry is laid out as bits [19:0] frame, bit 20 valid, bit 21 read allowed, bit 22 write allowed and bit 23 execute allowed. The response follows the edge on which `mem_rvalid_i` is sampled high.
- R3: A valid entry fetched on a miss is inserted into the cache, so a later request for the same page hits and returns the same frame.
- R4: A page number greater than or equal to the length register faults with cause 1 (range), reports no hit and reads no memory. The length register resets to 0.
- R5: An entry with its valid bit clear faults with cause 2 (invalid) and is not cached, so a repeat request reads memory again.
- R6: Access codes are 0 read, 1 write, 2 execute and 3 reserved, and the reserved code is never permitted. An access that the entry's permission bits do not allow faults with cause 3 (permission), both on a hit and after a table read. A valid entry is cached even when the access is denied.
- R7: A configuration write with `cfg_sel_i`=0 loads the base register, empties every slot and returns the victim pointer to slot 0. A write with `cfg_sel_i`=1 loads the length register and leaves the cache unchanged.
- R8: The cache has 8 slots. Refills go to the slot named by a victim pointer, which starts at slot 0 after reset or an empty, advances by one on each refill and wraps after slot 7.
- R9: `busy_o` is high from the cycle after a request is accepted until the response cycle, in which it is low. `req_valid_i` is ignored while `busy_o` is high.
- R10: `rsp_valid_o` is a one-cycle pulse. Cause 0 means success. On any fault `rsp_pfn_o` is 0. After reset the block is idle, with no response and no memory request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Translation request |
| req_vpn_i | input | 20 | Virtual page number |
| req_acc_i | input | 2 | Access type: 0 read, 1 write, 2 execute, 3 reserved |
| busy_o | output | 1 | A translation is in progress |
| rsp_valid_o | output | 1 | Response pulse |
| rsp_hit_o | output | 1 | The cache supplied the entry |
| rsp_pfn_o | output | 20 | Physical frame number, 0 on a fault |
| rsp_cause_o | output | 2 | 0 none, 1 range, 2 invalid, 3 permission |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_sel_i | input | 1 | 0 selects base, 1 selects length |
| cfg_wdata_i | input | 32 | Configuration write data |
| mem_req_o | output | 1 | Page-table read request, one cycle |
| mem_addr_o | output | 32 | Page-table entry address |
| mem_rvalid_i | input | 1 | Read data valid |
| mem_rdata_i | input | 24 | Page-table entry |

## Verification
The bench fills nine distinct pages so that the ninth refill wraps the victim pointer. A wrong replacement order would then either keep the oldest page hitting or evict a recent one. It re-requests pages whose entries are invalid; a design that cached those entries would answer from the cache without a memory read. It targets the length boundary (length minus one and length itself), where an off-by-one error either reads past the table or faults a legal page. It also switches the table base and expects misses that return the new table's frames, which a missing flush would serve stale. The bench drives a second request while busy, which a design that accepts it would answer twice. Permission checks use entries that deny one access type, requested both on the refill and later from the cache, along with the reserved access code.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_EXEC  = 2'd2,
    ACC_RSVD  = 2'd3
  } acc_e;

  typedef enum logic [1:0] {
    FLT_NONE    = 2'd0,
    FLT_RANGE   = 2'd1,
    FLT_INVALID = 2'd2,
    FLT_PERM    = 2'd3
  } flt_e;

  typedef struct packed {
    logic x;
    logic w;
    logic r;
  } perm_t;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_LOOK  = 2'd1,
    ST_MREQ  = 2'd2,
    ST_MWAIT = 2'd3
  } st_e;
endpackage

// File: rtl/xlat_cache.sv
module xlat_cache
  import xlat_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int VPN_W   = 20,
  parameter int PFN_W   = 20
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             flush_i,
  input  logic [VPN_W-1:0] lookup_vpn_i,
  output logic             hit_o,
  output logic [PFN_W-1:0] hit_pfn_o,
  output perm_t            hit_perm_o,
  input  logic             fill_i,
  input  logic [VPN_W-1:0] fill_vpn_i,
  input  logic [PFN_W-1:0] fill_pfn_i,
  input  perm_t            fill_perm_i
);
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

  logic [ENTRIES-1:0] vld_q;
  logic [VPN_W-1:0]   vpn_q  [ENTRIES];
  logic [PFN_W-1:0]   pfn_q  [ENTRIES];
  perm_t              perm_q [ENTRIES];
  logic [IDX_W-1:0]   victim_q;
  logic [ENTRIES-1:0] match;

  // parallel compare across all slots
  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign match[g] = vld_q[g] && (vpn_q[g] == lookup_vpn_i);
  end

  always_comb begin
    hit_o      = |match;
    hit_pfn_o  = '0;
    hit_perm_o = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      hit_pfn_o  = hit_pfn_o | ({PFN_W{match[i]}} & pfn_q[i]);
      hit_perm_o = hit_perm_o | ({3{match[i]}} & perm_q[i]);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q    <= '0;
      victim_q <= '0;
      for (int i = 0; i < ENTRIES; i++) begin
        vpn_q[i]  <= '0;
        pfn_q[i]  <= '0;
        perm_q[i] <= '0;
      end
    end else if (flush_i) begin
      vld_q    <= '0;
      victim_q <= '0;
    end else if (fill_i) begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (victim_q == IDX_W'(i)) begin
          vld_q[i]  <= 1'b1;
          vpn_q[i]  <= fill_vpn_i;
          pfn_q[i]  <= fill_pfn_i;
          perm_q[i] <= fill_perm_i;
        end
      end
      victim_q <= (victim_q == LAST) ? '0 : victim_q + 1'b1;
    end
  end
endmodule

// File: rtl/xlat_perm_chk.sv
module xlat_perm_chk
  import xlat_pkg::*;
(
  input  logic [1:0] acc_i,
  input  perm_t      perm_i,
  output logic       ok_o
);
  always_comb begin
    case (acc_e'(acc_i))
      ACC_READ:  ok_o = perm_i.r;
      ACC_WRITE: ok_o = perm_i.w;
      ACC_EXEC:  ok_o = perm_i.x;
      default:   ok_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/xlat_ctrl.sv
module xlat_ctrl
  import xlat_pkg::*;
#(
  parameter int VPN_W  = 20,
  parameter int PFN_W  = 20,
  parameter int ADDR_W = 32,
  parameter int PTE_W  = PFN_W + 4,
  parameter int LEN_W  = VPN_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [VPN_W-1:0]  req_vpn_i,
  input  logic [1:0]        req_acc_i,
  output logic              busy_o,
  output logic              rsp_valid_o,
  output logic              rsp_hit_o,
  output logic [PFN_W-1:0]  rsp_pfn_o,
  output logic [1:0]        rsp_cause_o,
  input  logic              cfg_we_i,
  input  logic              cfg_sel_i,
  input  logic [ADDR_W-1:0] cfg_wdata_i,
  output logic              mem_req_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic              mem_rvalid_i,
  input  logic [PTE_W-1:0]  mem_rdata_i,
  output logic [VPN_W-1:0]  look_vpn_o,
  input  logic              hit_i,
  input  logic [PFN_W-1:0]  hit_pfn_i,
  input  perm_t             hit_perm_i,
  output logic              flush_o,
  output logic              fill_o,
  output logic [PFN_W-1:0]  fill_pfn_o,
  output perm_t             fill_perm_o,
  output logic [1:0]        chk_acc_o,
  output perm_t             chk_perm_o,
  input  logic              chk_ok_i,
  output logic [ADDR_W-1:0] base_o,
  output logic [LEN_W-1:0]  len_o
);
  localparam int V_BIT = PFN_W;

  st_e               state_q;
  logic [VPN_W-1:0]  vpn_q;
  logic [1:0]        acc_q;
  logic [ADDR_W-1:0] base_q;
  logic [LEN_W-1:0]  len_q;
  logic              rsp_valid_q, rsp_hit_q;
  logic [PFN_W-1:0]  rsp_pfn_q;
  logic [1:0]        rsp_cause_q;
  logic              pte_v, in_range;

  assign pte_v       = mem_rdata_i[V_BIT];
  assign fill_pfn_o  = mem_rdata_i[PFN_W-1:0];
  assign fill_perm_o = perm_t'(mem_rdata_i[PTE_W-1:V_BIT+1]);
  assign in_range    = {1'b0, vpn_q} < len_q;

  assign busy_o      = (state_q != ST_IDLE);
  assign look_vpn_o  = vpn_q;
  assign mem_req_o   = (state_q == ST_MREQ);
  assign mem_addr_o  = base_q + ADDR_W'(vpn_q);
  assign flush_o     = cfg_we_i && !cfg_sel_i;
  assign fill_o      = (state_q == ST_MWAIT) && mem_rvalid_i && pte_v;
  assign chk_acc_o   = acc_q;
  assign chk_perm_o  = (state_q == ST_LOOK) ? hit_perm_i : fill_perm_o;
  assign base_o      = base_q;
  assign len_o       = len_q;

  assign rsp_valid_o = rsp_valid_q;
  assign rsp_hit_o   = rsp_hit_q;
  assign rsp_pfn_o   = rsp_pfn_q;
  assign rsp_cause_o = rsp_cause_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      vpn_q       <= '0;
      acc_q       <= '0;
      base_q      <= '0;
      len_q       <= '0;
      rsp_valid_q <= 1'b0;
      rsp_hit_q   <= 1'b0;
      rsp_pfn_q   <= '0;
      rsp_cause_q <= FLT_NONE;
    end else begin
      rsp_valid_q <= 1'b0;
      if (cfg_we_i) begin
        if (cfg_sel_i) len_q  <= cfg_wdata_i[LEN_W-1:0];
        else           base_q <= cfg_wdata_i;
      end
      case (state_q)
        ST_IDLE: begin
          if (req_valid_i) begin
            vpn_q   <= req_vpn_i;
            acc_q   <= req_acc_i;
            state_q <= ST_LOOK;
          end
        end
        ST_LOOK: begin
          if (!in_range) begin
            rsp_valid_q <= 1'b1;
            rsp_hit_q   <= 1'b0;
            rsp_pfn_q   <= '0;
            rsp_cause_q <= FLT_RANGE;
            state_q     <= ST_IDLE;
          end else if (hit_i) begin
            rsp_valid_q <= 1'b1;
            rsp_hit_q   <= 1'b1;
            rsp_pfn_q   <= chk_ok_i ? hit_pfn_i : '0;
            rsp_cause_q <= chk_ok_i ? FLT_NONE : FLT_PERM;
            state_q     <= ST_IDLE;
          end else begin
            state_q <= ST_MREQ;
          end
        end
        ST_MREQ: state_q <= ST_MWAIT;
        ST_MWAIT: begin
          if (mem_rvalid_i) begin
            rsp_valid_q <= 1'b1;
            rsp_hit_q   <= 1'b0;
            if (!pte_v) begin
              rsp_pfn_q   <= '0;
              rsp_cause_q <= FLT_INVALID;
            end else begin
              rsp_pfn_q   <= chk_ok_i ? fill_pfn_o : '0;
              rsp_cause_q <= chk_ok_i ? FLT_NONE : FLT_PERM;
            end
            state_q <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/xlat_unit.sv
module xlat_unit
  import xlat_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int VPN_W   = 20,
  parameter int PFN_W   = 20,
  parameter int ADDR_W  = 32,
  parameter int PTE_W   = PFN_W + 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [VPN_W-1:0]  req_vpn_i,
  input  logic [1:0]        req_acc_i,
  output logic              busy_o,
  output logic              rsp_valid_o,
  output logic              rsp_hit_o,
  output logic [PFN_W-1:0]  rsp_pfn_o,
  output logic [1:0]        rsp_cause_o,
  input  logic              cfg_we_i,
  input  logic              cfg_sel_i,
  input  logic [ADDR_W-1:0] cfg_wdata_i,
  output logic              mem_req_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic              mem_rvalid_i,
  input  logic [PTE_W-1:0]  mem_rdata_i
);
  localparam int LEN_W = VPN_W + 1;

  logic [VPN_W-1:0]  look_vpn;
  logic              hit, flush, fill, chk_ok;
  logic [PFN_W-1:0]  hit_pfn, fill_pfn;
  perm_t             hit_perm, fill_perm, chk_perm;
  logic [1:0]        chk_acc;
  logic [ADDR_W-1:0] tbl_base;
  logic [LEN_W-1:0]  tbl_len;

  xlat_cache #(
    .ENTRIES(ENTRIES), .VPN_W(VPN_W), .PFN_W(PFN_W)
  ) u_cache (
    .clk_i, .rst_ni,
    .flush_i(flush), .lookup_vpn_i(look_vpn),
    .hit_o(hit), .hit_pfn_o(hit_pfn), .hit_perm_o(hit_perm),
    .fill_i(fill), .fill_vpn_i(look_vpn),
    .fill_pfn_i(fill_pfn), .fill_perm_i(fill_perm)
  );

  xlat_perm_chk u_perm (
    .acc_i(chk_acc), .perm_i(chk_perm), .ok_o(chk_ok)
  );

  xlat_ctrl #(
    .VPN_W(VPN_W), .PFN_W(PFN_W), .ADDR_W(ADDR_W), .PTE_W(PTE_W), .LEN_W(LEN_W)
  ) u_ctrl (
    .clk_i, .rst_ni,
    .req_valid_i, .req_vpn_i, .req_acc_i, .busy_o,
    .rsp_valid_o, .rsp_hit_o, .rsp_pfn_o, .rsp_cause_o,
    .cfg_we_i, .cfg_sel_i, .cfg_wdata_i,
    .mem_req_o, .mem_addr_o, .mem_rvalid_i, .mem_rdata_i,
    .look_vpn_o(look_vpn), .hit_i(hit), .hit_pfn_i(hit_pfn), .hit_perm_i(hit_perm),
    .flush_o(flush), .fill_o(fill), .fill_pfn_o(fill_pfn), .fill_perm_o(fill_perm),
    .chk_acc_o(chk_acc), .chk_perm_o(chk_perm), .chk_ok_i(chk_ok),
    .base_o(tbl_base), .len_o(tbl_len)
  );
endmodule

// File: rtl/xlat_unit_chk.sv
module xlat_unit_chk #(
  parameter int PFN_W  = 20,
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 21
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_i,
  input logic              busy_o,
  input logic              rsp_valid_o,
  input logic              rsp_hit_o,
  input logic [PFN_W-1:0]  rsp_pfn_o,
  input logic [1:0]        rsp_cause_o,
  input logic              mem_req_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic [ADDR_W-1:0] tbl_base,
  input logic [LEN_W-1:0]  tbl_len
);
  AST_HIT_NO_WALK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && rsp_hit_o |-> !$past(mem_req_o)); // R1
  AST_WALK_WHILE_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> busy_o); // R2
  AST_WALK_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> ((mem_addr_o - tbl_base) < ADDR_W'(tbl_len))); // R4
  AST_ACCEPT_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && !busy_o |=> busy_o); // R9
  AST_RSP_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> !busy_o); // R9
  AST_RSP_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> !rsp_valid_o); // R10
  AST_FAULT_ZERO_PFN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && (rsp_cause_o != 2'd0) |-> (rsp_pfn_o == '0)); // R10
endmodule

bind xlat_unit xlat_unit_chk #(
  .PFN_W(PFN_W), .ADDR_W(ADDR_W), .LEN_W(VPN_W + 1)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_valid_i(req_valid_i), .busy_o(busy_o),
  .rsp_valid_o(rsp_valid_o), .rsp_hit_o(rsp_hit_o), .rsp_pfn_o(rsp_pfn_o),
  .rsp_cause_o(rsp_cause_o), .mem_req_o(mem_req_o), .mem_addr_o(mem_addr_o),
  .tbl_base(tbl_base), .tbl_len(tbl_len)
);

// File: tb/xlat_unit_bench.sv
module xlat_unit_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid_i = 1'b0;
  logic [19:0] req_vpn_i = '0;
  logic [1:0]  req_acc_i = '0;
  logic        busy_o, rsp_valid_o, rsp_hit_o;
  logic [19:0] rsp_pfn_o;
  logic [1:0]  rsp_cause_o;
  logic        cfg_we_i = 1'b0;
  logic        cfg_sel_i = 1'b0;
  logic [31:0] cfg_wdata_i = '0;
  logic        mem_req_o;
  logic [31:0] mem_addr_o;
  logic        mem_rvalid_i = 1'b0;
  logic [23:0] mem_rdata_i = '0;

  int errors = 0;
  int checks = 0;
  int mem_reads = 0;
  logic [31:0] last_addr = '0;

  // reference cache and table state
  logic [19:0] m_vpn [8];
  logic [19:0] m_pfn [8];
  logic [2:0]  m_perm [8];
  logic        m_vld [8];
  int          m_ptr = 0;
  logic [31:0] m_base = '0;
  int          m_len = 0;

  always #4 clk_i = ~clk_i;

  xlat_unit u_xlat_unit (.*);

  function automatic logic [23:0] pte_fn(input logic [31:0] a);
    logic [31:0] h;
    h = a * 32'h9E37 + 32'h1234;
    if (a[15:12] == 4'h1) return {4'b1111, h[19:0]};
    return {a[5], a[4], a[3], (a[2:0] != 3'd0), h[19:0]};
  endfunction

  function automatic logic allowed(input logic [1:0] acc, input logic [2:0] p);
    case (acc)
      2'd0: return p[0];
      2'd1: return p[1];
      2'd2: return p[2];
      default: return 1'b0;
    endcase
  endfunction

  // single-cycle-latency page-table memory
  always @(posedge clk_i) begin
    mem_rvalid_i <= 1'b0;
    if (mem_req_o) begin
      mem_rvalid_i <= 1'b1;
      mem_rdata_i  <= pte_fn(mem_addr_o);
      last_addr    <= mem_addr_o;
      mem_reads    <= mem_reads + 1;
    end
  end

  task automatic check(input logic ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic model_flush();
    for (int i = 0; i < 8; i++) m_vld[i] = 1'b0;
    m_ptr = 0;
  endtask

  task automatic model_eval(input logic [19:0] vpn, input logic [1:0] acc,
                            output logic e_hit, output logic [1:0] e_cause,
                            output logic [19:0] e_pfn, output int e_reads);
    int idx;
    logic [23:0] pte;
    idx = -1;
    e_hit = 1'b0; e_cause = 2'd0; e_pfn = '0; e_reads = 0;
    if (int'(vpn) >= m_len) begin
      e_cause = 2'd1;
      return;
    end
    for (int i = 0; i < 8; i++) if (m_vld[i] && m_vpn[i] == vpn) idx = i;
    if (idx >= 0) begin
      e_hit = 1'b1;
      if (allowed(acc, m_perm[idx])) e_pfn = m_pfn[idx];
      else e_cause = 2'd3;
      return;
    end
    e_reads = 1;
    pte = pte_fn(m_base + 32'(vpn));
    if (!pte[20]) begin
      e_cause = 2'd2;
      return;
    end
    m_vpn[m_ptr] = vpn; m_pfn[m_ptr] = pte[19:0]; m_perm[m_ptr] = pte[23:21];
    m_vld[m_ptr] = 1'b1;
    m_ptr = (m_ptr + 1) % 8;
    if (allowed(acc, pte[23:21])) e_pfn = pte[19:0];
    else e_cause = 2'd3;
  endtask

  task automatic cfg_write(input logic sel, input logic [31:0] data);
    @(negedge clk_i);
    cfg_we_i = 1'b1; cfg_sel_i = sel; cfg_wdata_i = data;
    @(posedge clk_i);
    @(negedge clk_i);
    cfg_we_i = 1'b0;
    if (!sel) begin m_base = data; model_flush(); end
    else m_len = int'(data[20:0]);
  endtask

  task automatic wait_rsp(output int n);
    n = 0;
    while (!rsp_valid_o && n < 40) begin @(negedge clk_i); n++; end
  endtask

  task automatic check_rsp(input string tag, input int n, input int r0,
                           input logic [19:0] vpn, input logic e_hit,
                           input logic [1:0] e_cause, input logic [19:0] e_pfn,
                           input int e_reads);
    int e_lat;
    e_lat = (e_reads == 1) ? 3 : 1;
    check(rsp_valid_o, tag, "rsp_valid", 32'(rsp_valid_o), 32'd1);
    check(rsp_hit_o == e_hit, tag, "hit", 32'(rsp_hit_o), 32'(e_hit));
    check(rsp_cause_o == e_cause, tag, "cause", 32'(rsp_cause_o), 32'(e_cause));
    check(rsp_pfn_o == e_pfn, tag, "pfn", 32'(rsp_pfn_o), 32'(e_pfn));
    check(n == e_lat, tag, "latency", 32'(n), 32'(e_lat));
    check(mem_reads - r0 == e_reads, tag, "mem reads", 32'(mem_reads - r0), 32'(e_reads));
    if (e_reads == 1)
      check(last_addr == m_base + 32'(vpn), tag, "read address", last_addr, m_base + 32'(vpn));
    check(!busy_o, "R9", "busy in response cycle", 32'(busy_o), 32'd0);
    @(negedge clk_i);
    check(!rsp_valid_o, "R10", "response pulse width", 32'(rsp_valid_o), 32'd0);
  endtask

  task automatic xlate(input logic [19:0] vpn, input logic [1:0] acc, input string tag);
    logic e_hit; logic [1:0] e_cause; logic [19:0] e_pfn; int e_reads; int n; int r0;
    model_eval(vpn, acc, e_hit, e_cause, e_pfn, e_reads);
    @(negedge clk_i);
    r0 = mem_reads;
    req_valid_i = 1'b1; req_vpn_i = vpn; req_acc_i = acc;
    @(posedge clk_i);
    @(negedge clk_i);
    req_valid_i = 1'b0;
    check(busy_o, "R9", "busy after accept", 32'(busy_o), 32'd1);
    wait_rsp(n);
    check_rsp(tag, n, r0, vpn, e_hit, e_cause, e_pfn, e_reads);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog: actual=expired expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    logic e_hit; logic [1:0] e_cause; logic [19:0] e_pfn; int e_reads; int n; int r0;
    void'($urandom(32'h5EED_0042));
    model_flush();
    repeat (3) @(negedge clk_i);
    check(!busy_o && !rsp_valid_o && !mem_req_o, "R10", "reset idle",
          {29'd0, busy_o, rsp_valid_o, mem_req_o}, 32'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check(!busy_o && !rsp_valid_o && !mem_req_o, "R10", "idle after reset",
          {29'd0, busy_o, rsp_valid_o, mem_req_o}, 32'd0);

    xlate(20'd5, 2'd0, "R4");            // length resets to 0
    cfg_write(1'b0, 32'h1000);
    cfg_write(1'b1, 32'd64);
    xlate(20'd3, 2'd0, "R2");
    xlate(20'd3, 2'd1, "R3");
    xlate(20'd3, 2'd2, "R1");
    xlate(20'd64, 2'd0, "R4");
    xlate(20'd63, 2'd2, "R4");

    // round-robin: nine refills after an empty cache
    cfg_write(1'b0, 32'h1000);
    for (int v = 10; v < 19; v++) xlate(20'(v), 2'd0, "R8");
    xlate(20'd18, 2'd0, "R8");
    xlate(20'd11, 2'd0, "R8");
    xlate(20'd10, 2'd0, "R8");

    // table switch empties the cache; a length write does not
    xlate(20'd12, 2'd0, "R3");
    cfg_write(1'b1, 32'd63);
    xlate(20'd12, 2'd0, "R7");
    cfg_write(1'b0, 32'h1100);
    xlate(20'd12, 2'd0, "R7");
    xlate(20'd3, 2'd0, "R7");

    // invalid entries and permission faults
    cfg_write(1'b0, 32'h2000);
    cfg_write(1'b1, 32'd64);
    xlate(20'd8, 2'd0, "R5");
    xlate(20'd8, 2'd0, "R5");
    xlate(20'd1, 2'd0, "R6");
    xlate(20'd1, 2'd0, "R6");
    xlate(20'd9, 2'd0, "R6");
    xlate(20'd9, 2'd1, "R6");
    xlate(20'd9, 2'd3, "R6");
    xlate(20'h19, 2'd1, "R6");
    xlate(20'h21, 2'd2, "R6");
    xlate(20'h21, 2'd0, "R6");

    // second request while busy is ignored
    cfg_write(1'b0, 32'h1000);
    model_eval(20'd40, 2'd0, e_hit, e_cause, e_pfn, e_reads);
    @(negedge clk_i);
    r0 = mem_reads;
    req_valid_i = 1'b1; req_vpn_i = 20'd40; req_acc_i = 2'd0;
    @(posedge clk_i);
    @(negedge clk_i);
    req_vpn_i = 20'd41;
    @(posedge clk_i);
    @(negedge clk_i);
    req_valid_i = 1'b0;
    wait_rsp(n);
    check_rsp("R9", n + 1, r0, 20'd40, e_hit, e_cause, e_pfn, e_reads);
    for (int k = 0; k < 6; k++) begin
      check(!rsp_valid_o && !busy_o, "R9", "no response to ignored request",
            {30'd0, rsp_valid_o, busy_o}, 32'd0);
      @(negedge clk_i);
    end

    // constrained random mix
    for (int t = 0; t < 400; t++) begin
      if (t % 50 == 0) begin
        case ($urandom_range(0, 2))
          0: cfg_write(1'b0, 32'h1000);
          1: cfg_write(1'b0, 32'h2000);
          default: cfg_write(1'b0, 32'h3040);
        endcase
        cfg_write(1'b1, ($urandom_range(0, 1) == 0) ? 32'd64 : 32'd40);
      end
      xlate(20'($urandom_range(0, 79)), 2'($urandom_range(0, 3)), "R3");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule